// File: doc/BRIEF.md
# Egress Fragment Scheduler with Flow-Control Modes

This block chooses which of several ports sends its next packet fragment on a byte-lane egress bus. It then frames that fragment. Each fragment opens with a start-of-transfer cycle that carries the port number. A fixed number of data words follows. When the fragment ends a packet, the last word is marked as end-of-packet. Padding can be switched on separately for each marker. Each one then gets two extra dummy cycles, as some attached receivers require.

Two kinds of feedback from the attached device decide whether a port may be picked. In level mode, a per-port status line enables the port, and fragments keep going to it for as long as the line stays high. In credit mode, each credit pulse permits exactly one fragment. A pulse that arrives while a fragment is still on the bus is held and used later. Each port has three further controls: an enable, a reversal of bit order inside every byte, and a hold that stops a second burst until the device releases the first. A loopback switch takes egress data from the ingress side of the same port instead of from the buffer. The fragment memory sits outside the block and is read through a request, port and data interface.

Top module: `egs_sched_top`

## Requirements
- R1: After reset the egress bus is idle: eg_stx, eg_valid and eg_eop are 0 and eg_data is 0. All mode inputs default to level mode, single burst and no loopback.
- R2: A port whose port_en bit is 0, or whose frag_avail bit is 0, never starts a fragment.
- R3: In level mode (cfg_credit_mode=0), a port whose fc_status bit is 0 is not started. While that bit stays 1 and more bursts are allowed, the port is started again after each fragment.
- R4: In credit mode (cfg_credit_mode=1), each fc_credit pulse for a port permits exactly one fragment. A port that holds no credit is not started.
- R5: A credit pulse that arrives while that port's fragment is on the bus is kept, and one more fragment is sent after the current one ends.
- R6: A fragment opens with one eg_stx cycle that has the port number in the low bits of eg_data. With cfg_stx_pad=1, two more eg_stx cycles follow, so there are 3 in all.
- R7: FRAG_WORDS (default 4) data cycles with eg_valid=1 follow. If the latched frag_eop bit is 1, eg_eop is 1 on the last of them. With cfg_eop_pad=1 and a packet end, two more cycles follow that have eg_eop=1 and eg_valid=0.
- R8: When port_bitrev is set for the active port, bit i of every byte of the data moves to bit 7-i.
- R9: With cfg_multi_burst=0, a port that has started a fragment is not started again until a burst_release pulse for that port. With cfg_multi_burst=1, this hold does not apply.
- R10: With cfg_loopback=1, data words are taken from lb_data instead of buf_data.
- R11: Eligible ports are served round robin. After reset the search begins at port 0, and after a grant it begins at the next higher port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_credit_mode | input | 1 | 0 = level status, 1 = credit pulses |
| cfg_multi_burst | input | 1 | Allow more than one burst per port |
| cfg_stx_pad | input | 1 | Add two dummy start cycles |
| cfg_eop_pad | input | 1 | Add two dummy end-of-packet cycles |
| cfg_loopback | input | 1 | Take data from lb_data |
| port_en | input | NPORTS | Per-port enable |
| port_bitrev | input | NPORTS | Per-port bit reversal inside bytes |
| frag_avail | input | NPORTS | Buffer holds a fragment for the port |
| frag_eop | input | NPORTS | That fragment ends a packet |
| fc_status | input | NPORTS | Level flow-control status |
| fc_credit | input | NPORTS | Credit pulses |
| burst_release | input | NPORTS | Device has drained the port's burst |
| buf_data | input | 8*BYTES | Buffer word for rd_port |
| lb_data | input | 8*BYTES | Loopback word for rd_port |
| rd_req | output | 1 | Buffer word is consumed this cycle |
| rd_port | output | $clog2(NPORTS) | Port being read |
| eg_stx | output | 1 | Start-of-transfer cycle |
| eg_valid | output | 1 | Data cycle |
| eg_eop | output | 1 | End-of-packet marker |
| eg_data | output | 8*BYTES | Egress bus |

## Verification
A port that is eligible at a rising edge while the scheduler is idle shows its first eg_stx in the cycle that follows that edge. The padding, data and end-of-packet cycles then follow one per cycle. The next fragment cannot begin until at least one idle cycle has passed. The bench changes inputs only on falling edges and samples every cycle on falling edges. It follows the first fragment phase by phase (start, data, dummy end), so each count and data value is compared in the cycle where it is due. Credit and release pulses are driven in parallel with this sampling, so that they land at a known offset from the start of the fragment.

// File: rtl/egs_pkg.sv
package egs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STX,
    ST_STXPAD1,
    ST_STXPAD2,
    ST_DATA,
    ST_EOPPAD1,
    ST_EOPPAD2
  } egs_state_e;
endpackage

// File: rtl/egs_elig.sv
module egs_elig #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              credit_mode,
  input  logic              multi_burst,
  input  logic [NPORTS-1:0] port_en,
  input  logic [NPORTS-1:0] frag_avail,
  input  logic [NPORTS-1:0] fc_status,
  input  logic [NPORTS-1:0] fc_credit,
  input  logic [NPORTS-1:0] burst_release,
  input  logic [NPORTS-1:0] start_vec,
  output logic [NPORTS-1:0] elig
);
  logic [NPORTS-1:0] cred_q, cred_d;
  logic [NPORTS-1:0] busy_q, busy_d;

  always_comb begin
    cred_d = (cred_q & ~start_vec) | fc_credit;
    busy_d = (busy_q & ~burst_release) | start_vec;
    elig   = port_en & frag_avail
           & (credit_mode ? cred_q : fc_status)
           & (multi_burst ? {NPORTS{1'b1}} : ~busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= '0;
      busy_q <= '0;
    end else begin
      cred_q <= cred_d;
      busy_q <= busy_d;
    end
  end

  // R4
  credit_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_mode && (|start_vec)) |-> (|(start_vec & cred_q)));

  // R9
  single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi_burst && (|start_vec)) |-> !(|(start_vec & busy_q)));
endmodule

// File: rtl/egs_rr_arb.sv
module egs_rr_arb #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] elig,
  input  logic              take,
  output logic [NPORTS-1:0] gnt_vec,
  output logic [PW-1:0]     gnt_idx,
  output logic              gnt_any
);
  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = 1; i <= NPORTS; i++) begin
      int j;
      j = (int'(ptr_q) + i) % NPORTS;
      if (!gnt_any && elig[j]) begin
        gnt_any = 1'b1;
        gnt_idx = PW'(j);
      end
    end
    gnt_vec = '0;
    gnt_vec[gnt_idx] = gnt_any;
    ptr_d = take ? gnt_idx : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= PW'(NPORTS - 1);
    else        ptr_q <= ptr_d;
  end

  // R11
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec) && ((gnt_vec & ~elig) == '0));
endmodule

// File: rtl/egs_byte_rev.sv
module egs_byte_rev #(
  parameter int BYTES = 4,
  localparam int DW = 8 * BYTES
) (
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign q[8*b+i] = d[8*b+7-i];
    end
  end
endmodule

// File: rtl/egs_framer.sv
module egs_framer
  import egs_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int FRAG_WORDS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int CW = (FRAG_WORDS > 1) ? $clog2(FRAG_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] gnt_idx,
  input  logic          gnt_eop,
  input  logic          stx_pad,
  input  logic          eop_pad,
  output logic          idle,
  output logic          in_stx,
  output logic          in_data,
  output logic          in_eoppad,
  output logic          last_eop,
  output logic [PW-1:0] cur_port
);
  egs_state_e    state_q, state_d;
  logic [PW-1:0] port_q, port_d;
  logic [CW-1:0] word_q, word_d;
  logic          eop_q, eop_d;
  logic          last_word;

  assign last_word = (word_q == CW'(FRAG_WORDS - 1));

  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    word_d  = word_q;
    eop_d   = eop_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_STX;
        port_d  = gnt_idx;
        eop_d   = gnt_eop;
        word_d  = '0;
      end
      ST_STX:     state_d = stx_pad ? ST_STXPAD1 : ST_DATA;
      ST_STXPAD1: state_d = ST_STXPAD2;
      ST_STXPAD2: state_d = ST_DATA;
      ST_DATA: begin
        if (last_word) state_d = (eop_q && eop_pad) ? ST_EOPPAD1 : ST_IDLE;
        else           word_d  = word_q + 1'b1;
      end
      ST_EOPPAD1: state_d = ST_EOPPAD2;
      ST_EOPPAD2: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      word_q  <= '0;
      eop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      port_q  <= port_d;
      word_q  <= word_d;
      eop_q   <= eop_d;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign in_stx    = (state_q == ST_STX) || (state_q == ST_STXPAD1) || (state_q == ST_STXPAD2);
  assign in_data   = (state_q == ST_DATA);
  assign in_eoppad = (state_q == ST_EOPPAD1) || (state_q == ST_EOPPAD2);
  assign last_eop  = in_data && last_word && eop_q;
  assign cur_port  = port_q;

  // R7
  eop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && last_word) |=> !in_data);
endmodule

// File: rtl/egs_sched_top.sv
module egs_sched_top #(
  parameter int NPORTS     = 4,
  parameter int BYTES      = 4,
  parameter int FRAG_WORDS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int DW = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_credit_mode,
  input  logic              cfg_multi_burst,
  input  logic              cfg_stx_pad,
  input  logic              cfg_eop_pad,
  input  logic              cfg_loopback,
  input  logic [NPORTS-1:0] port_en,
  input  logic [NPORTS-1:0] port_bitrev,
  input  logic [NPORTS-1:0] frag_avail,
  input  logic [NPORTS-1:0] frag_eop,
  input  logic [NPORTS-1:0] fc_status,
  input  logic [NPORTS-1:0] fc_credit,
  input  logic [NPORTS-1:0] burst_release,
  input  logic [DW-1:0]     buf_data,
  input  logic [DW-1:0]     lb_data,
  output logic              rd_req,
  output logic [PW-1:0]     rd_port,
  output logic              eg_stx,
  output logic              eg_valid,
  output logic              eg_eop,
  output logic [DW-1:0]     eg_data
);
  logic [NPORTS-1:0] elig, gnt_vec, start_vec;
  logic [PW-1:0]     gnt_idx, cur_port;
  logic              gnt_any, start, idle;
  logic              in_stx, in_data, in_eoppad, last_eop;
  logic [DW-1:0]     src_word, rev_word;

  assign start     = idle && gnt_any;
  assign start_vec = gnt_vec & {NPORTS{start}};

  egs_elig #(.NPORTS(NPORTS)) u_elig (
    .clk(clk), .rst_n(rst_n),
    .credit_mode(cfg_credit_mode), .multi_burst(cfg_multi_burst),
    .port_en(port_en), .frag_avail(frag_avail), .fc_status(fc_status),
    .fc_credit(fc_credit), .burst_release(burst_release),
    .start_vec(start_vec), .elig(elig)
  );

  egs_rr_arb #(.NPORTS(NPORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .take(start),
    .gnt_vec(gnt_vec), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  egs_framer #(.NPORTS(NPORTS), .FRAG_WORDS(FRAG_WORDS)) u_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .gnt_idx(gnt_idx),
    .gnt_eop(frag_eop[gnt_idx]), .stx_pad(cfg_stx_pad), .eop_pad(cfg_eop_pad),
    .idle(idle), .in_stx(in_stx), .in_data(in_data), .in_eoppad(in_eoppad),
    .last_eop(last_eop), .cur_port(cur_port)
  );

  assign src_word = cfg_loopback ? lb_data : buf_data;

  egs_byte_rev #(.BYTES(BYTES)) u_rev (.d(src_word), .q(rev_word));

  always_comb begin
    eg_data = '0;
    if (in_stx)       eg_data = DW'(cur_port);
    else if (in_data) eg_data = port_bitrev[cur_port] ? rev_word : src_word;
  end

  assign eg_stx   = in_stx;
  assign eg_valid = in_data;
  assign eg_eop   = last_eop || in_eoppad;
  assign rd_req   = in_data;
  assign rd_port  = cur_port;

  // R2
  start_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (port_en[gnt_idx] && frag_avail[gnt_idx]));
endmodule

// File: tb/egs_sched_top_tb.sv
module egs_sched_top_tb;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam logic [DW-1:0] BUFW = 32'h0102_0380;
  localparam logic [DW-1:0] BUFR = 32'h8040_C001;
  localparam logic [DW-1:0] LBW  = 32'hA5A5_0F0F;

  // {stxpad, eoppad, feop[4], en[4], avail[4], status[4], rev[4], xport[2], xstx[2], xeop[2], xrev}
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 2'd0, 2'd1, 2'd1, 1'b0},
    {1'b1, 1'b1, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 2'd0, 2'd3, 2'd3, 1'b0},
    {1'b0, 1'b0, 4'hF, 4'hE, 4'hF, 4'hF, 4'h2, 2'd1, 2'd1, 2'd1, 1'b1},
    {1'b0, 1'b1, 4'h0, 4'hF, 4'h8, 4'hF, 4'h0, 2'd3, 2'd1, 2'd0, 1'b0},
    {1'b1, 1'b0, 4'hF, 4'hF, 4'hC, 4'h5, 4'h4, 2'd2, 2'd3, 2'd1, 1'b1},
    {1'b0, 1'b1, 4'h2, 4'h7, 4'hA, 4'hF, 4'h0, 2'd1, 2'd1, 2'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_credit_mode, cfg_multi_burst, cfg_stx_pad, cfg_eop_pad, cfg_loopback;
  logic [NP-1:0] port_en, port_bitrev, frag_avail, frag_eop, fc_status, fc_credit, burst_release;
  logic [DW-1:0] buf_data, lb_data, eg_data;
  logic rd_req, eg_stx, eg_valid, eg_eop;
  logic [1:0] rd_port;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int n_starts, stxc, vc, eopc;
  logic [DW-1:0] port0, port1, d0;

  always #2 clk = ~clk;

  egs_sched_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_credit_mode(cfg_credit_mode), .cfg_multi_burst(cfg_multi_burst),
    .cfg_stx_pad(cfg_stx_pad), .cfg_eop_pad(cfg_eop_pad), .cfg_loopback(cfg_loopback),
    .port_en(port_en), .port_bitrev(port_bitrev), .frag_avail(frag_avail),
    .frag_eop(frag_eop), .fc_status(fc_status), .fc_credit(fc_credit),
    .burst_release(burst_release), .buf_data(buf_data), .lb_data(lb_data),
    .rd_req(rd_req), .rd_port(rd_port), .eg_stx(eg_stx), .eg_valid(eg_valid),
    .eg_eop(eg_eop), .eg_data(eg_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    cfg_credit_mode = 0; cfg_multi_burst = 0; cfg_stx_pad = 0; cfg_eop_pad = 0;
    cfg_loopback = 0; port_en = '0; port_bitrev = '0; frag_avail = '0;
    frag_eop = '0; fc_status = '0; fc_credit = '0; burst_release = '0;
    buf_data = BUFW; lb_data = LBW;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // follows the first fragment phase by phase; counts all starts in the window
  task automatic observe(input int ncyc);
    int phase;
    bit prev_stx;
    phase = 0; prev_stx = 0;
    n_starts = 0; stxc = 0; vc = 0; eopc = 0; port0 = '1; port1 = '1; d0 = '0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (eg_stx && !prev_stx) begin
        if (n_starts == 0) port0 = eg_data;
        if (n_starts == 1) port1 = eg_data;
        n_starts++;
      end
      case (phase)
        0: if (eg_stx) begin phase = 1; stxc = 1; end
        1: if (eg_stx) stxc++;
           else if (eg_valid) begin phase = 2; vc = 1; d0 = eg_data; if (eg_eop) eopc = 1; end
        2: if (eg_valid) begin vc++; if (eg_eop) eopc++; end
           else if (eg_eop) begin eopc++; phase = 3; end
           else phase = 4;
        3: if (eg_eop && !eg_valid && !eg_stx) eopc++; else phase = 4;
        default: ;
      endcase
      prev_stx = eg_stx;
    end
  endtask

  task automatic pulse_credit(input int wait_cyc, input logic [NP-1:0] m);
    repeat (wait_cyc) @(negedge clk);
    fc_credit = m;
    @(negedge clk);
    fc_credit = '0;
  endtask

  task automatic pulse_release(input int wait_cyc, input logic [NP-1:0] m);
    repeat (wait_cyc) @(negedge clk);
    burst_release = m;
    @(negedge clk);
    burst_release = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    @(negedge clk);
    // R1 reset state
    chk(!eg_stx && !eg_valid && !eg_eop && eg_data == '0, "R1 reset idle",
        {eg_stx, eg_valid, eg_eop}, 0);
    do_reset();
    @(negedge clk);
    chk(!eg_stx && !eg_valid && !eg_eop && eg_data == '0, "R1 idle after release", eg_data, 0);

    // table of framing vectors (R6 R7 R8 R11 R2 R3)
    for (int v = 0; v < NV; v++) begin
      logic [28:0] t;
      t = VEC[v];
      clear_inputs();
      cfg_stx_pad = t[28]; cfg_eop_pad = t[27]; frag_eop = t[26:23];
      port_en = t[22:19]; frag_avail = t[18:15]; fc_status = t[14:11];
      port_bitrev = t[10:7];
      do_reset();
      observe(24);
      chk(n_starts >= 1, $sformatf("R2 vec%0d start seen", v), n_starts, 1);
      chk(port0 == DW'(t[6:5]), $sformatf("R11 vec%0d port", v), port0, t[6:5]);
      chk(stxc == int'(t[4:3]), $sformatf("R6 vec%0d stx cycles", v), stxc, t[4:3]);
      chk(vc == 4, $sformatf("R7 vec%0d data cycles", v), vc, 4);
      chk(eopc == int'(t[2:1]), $sformatf("R7 vec%0d eop cycles", v), eopc, t[2:1]);
      chk(d0 == (t[0] ? BUFR : BUFW), $sformatf("R8 vec%0d data", v), d0, t[0] ? BUFR : BUFW);
    end

    // R2 disabled ports never start
    clear_inputs(); frag_avail = '1; fc_status = '1; cfg_multi_burst = 1;
    do_reset(); observe(24);
    chk(n_starts == 0, "R2 all disabled", n_starts, 0);

    // R3 status low blocks; status high keeps sending
    clear_inputs(); port_en = '1; frag_avail = 4'h4; cfg_multi_burst = 1;
    do_reset(); observe(24);
    chk(n_starts == 0, "R3 status low", n_starts, 0);
    fc_status = 4'h4; observe(30);
    chk(n_starts >= 2 && port1 == 2, "R3 repeated sends", n_starts, 2);

    // R4 credit mode: no credit, then one credit one fragment
    clear_inputs(); cfg_credit_mode = 1; cfg_multi_burst = 1; port_en = '1;
    frag_avail = 4'h2; fc_status = '1;
    do_reset(); observe(20);
    chk(n_starts == 0, "R4 no credit", n_starts, 0);
    fork
      observe(40);
      pulse_credit(1, 4'h2);
    join
    chk(n_starts == 1 && port0 == 1, "R4 one credit one fragment", n_starts, 1);

    // R5 credit arriving mid-fragment is kept
    fork
      observe(40);
      begin pulse_credit(1, 4'h2); pulse_credit(3, 4'h2); end
    join
    chk(n_starts == 2, "R5 latched credit", n_starts, 2);

    // R9 single burst holds until release
    clear_inputs(); port_en = '1; frag_avail = 4'h4; fc_status = '1;
    do_reset(); observe(30);
    chk(n_starts == 1, "R9 held after one burst", n_starts, 1);
    fork
      observe(30);
      pulse_release(2, 4'h4);
    join
    chk(n_starts == 1, "R9 release allows one more", n_starts, 1);
    cfg_multi_burst = 1; observe(30);
    chk(n_starts >= 2, "R9 multi burst", n_starts, 2);

    // R10 loopback source
    clear_inputs(); cfg_loopback = 1; port_en = '1; frag_avail = 4'h1; fc_status = '1;
    do_reset(); observe(20);
    chk(d0 == LBW, "R10 loopback data", d0, LBW);

    // R11 round robin order
    clear_inputs(); cfg_multi_burst = 1; port_en = '1; frag_avail = 4'h6; fc_status = '1;
    do_reset(); observe(30);
    chk(port0 == 1 && port1 == 2, "R11 rotation", {port0[7:0], port1[7:0]}, 16'h0102);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule